// File: doc/BRIEF.md
# Sticky Status Word with Two Masked Interrupt Lines

This block gathers a storage controller's status into a single 22-bit word. The low eleven positions hold latched event flags. The command unit and the data engine raise these flags with single-cycle pulses, and each flag stays set until software clears it. The upper eleven positions show the transfer-active and FIFO level flags exactly as the data engine drives them at that moment. They are not stored and cannot be cleared.

Software uses a small word-addressed register port with a write strobe. Reads are combinational from the address.

| Address | Access | Contents |
|---------|--------|----------|
| 0 | read | The status word, zero-extended to 32 bits. Writes are ignored. |
| 1 | write | Write-one-to-clear for the event flags. Reads return zero. |
| 2 | read/write | Mask for interrupt line A. |
| 3 | read/write | Mask for interrupt line B. |
| 4 to 7 | none | Read as zero. Writes are ignored. |

Each interrupt line is a registered OR over the status bits that its own mask enables. This lets one line serve data-path events and the other serve command events, for example.

Top module: `sirq_status_top`

## Requirements
- R1: While reset is held and in the first cycle after it, the event flags are zero, both masks read zero and both interrupt lines are low.
- R2: A pulse on `evt_pulse[i]`, for i in 0..8 or 10, sets status bit i at the next rising clock edge. The bit then stays set whatever later pulses do, until it is cleared.
- R3: Status bit 9 is reserved. A pulse on `evt_pulse[9]` never sets it, and it always reads zero.
- R4: A write to address 1 clears every event flag whose position is a one in `reg_wdata[10:0]`. The clear takes effect at that clock edge. Flags written as zero are kept, and `reg_wdata[31:11]` has no effect.
- R5: When a pulse and a clear of the same bit fall in the same cycle, the bit is set after that edge.
- R6: Status bits 21:11 equal `lvl_flags[10:0]` in the same cycle. A write to address 1 does not change them.
- R7: A write to address 2 or 3 stores all 32 bits of `reg_wdata` as the mask of line A or line B. The mask reads back unchanged at the same address.
- R8: At each rising edge, `irq_a` (or `irq_b`) takes the OR of the bitwise AND of the status word with mask A (or mask B) as it stood before that edge. Mask bits 31:22 have no effect.
- R9: A read of address 1 or of addresses 4 to 7 returns zero. A write to address 0 or to addresses 4 to 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 11 | Event pulses; bit i sets status bit i |
| lvl_flags | input | 11 | Live level flags shown as status bits 21:11 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq_a | output | 1 | Interrupt line A, registered |
| irq_b | output | 1 | Interrupt line B, registered |

## Verification
The hardest case to reach from the ports is a clear write whose ones overlap a pulse on the same bit in the same cycle. Random traffic seldom lines these up. A directed case forces the overlap on several bits at once. The random phase also aims most of its writes at the clear address and keeps events sparse, so that partial overlaps occur. Interrupt latency is checked every cycle against a model that takes the status and masks from before each edge. This covers level flags and mask writes that change an interrupt without any event.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int EVT_W  = 11;
  localparam int LVL_W  = 11;
  localparam int STAT_W = EVT_W + LVL_W;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;
  localparam int N_IRQ  = 2;
  // bit 9 of the event field is reserved
  localparam logic [EVT_W-1:0] EVT_VALID = 11'b101_1111_1111;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT  = 3'd0,
    A_CLR   = 3'd1,
    A_MASK0 = 3'd2,
    A_MASK1 = 3'd3
  } reg_addr_e;
endpackage

// File: rtl/sirq_evt_latch.sv
module sirq_evt_latch #(
  parameter int W = 11,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] clr_bits;
  logic [W-1:0] nxt;

  always_comb begin
    clr_bits = clr_en_i ? clr_val_i : '0;
    // set takes priority over a simultaneous clear
    nxt = ((q_o & ~clr_bits) | set_i) & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/sirq_regbank.sv
module sirq_regbank #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 3,
  parameter int STAT_W = 22,
  parameter int N_MASK = 2,
  parameter int CLR_ADDR  = 1,
  parameter int STAT_ADDR = 0,
  parameter int MASK_BASE = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  input  logic [STAT_W-1:0]            stat_i,
  output logic [REG_W-1:0]             rdata_o,
  output logic                         clr_en_o,
  output logic [REG_W-1:0]             clr_val_o,
  output logic [N_MASK-1:0][REG_W-1:0] mask_o
);
  logic [N_MASK-1:0] hit;

  for (genvar k = 0; k < N_MASK; k++) begin : g_mask
    assign hit[k] = (addr_i == ADDR_W'(MASK_BASE + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             mask_o[k] <= '0;
      else if (wr_i && hit[k]) mask_o[k] <= wdata_i;
    end
  end

  assign clr_en_o  = wr_i && (addr_i == ADDR_W'(CLR_ADDR));
  assign clr_val_o = wdata_i;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o = REG_W'(stat_i);
    for (int k = 0; k < N_MASK; k++)
      if (hit[k]) rdata_o = mask_o[k];
  end
endmodule

// File: rtl/sirq_irq_gen.sv
module sirq_irq_gen #(
  parameter int N      = 2,
  parameter int STAT_W = 22,
  parameter int REG_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [STAT_W-1:0]       stat_i,
  input  logic [N-1:0][REG_W-1:0] mask_i,
  output logic [N-1:0]            irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_line
    logic any_hit;
    assign any_hit = |(stat_i & mask_i[k][STAT_W-1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o[k] <= 1'b0;
      else        irq_o[k] <= any_hit;
    end
  end
endmodule

// File: rtl/sirq_status_top.sv
module sirq_status_top
  import sirq_pkg::*;
#(
  parameter int EW = EVT_W,
  parameter int LW = LVL_W,
  parameter int RW = REG_W,
  parameter int AW = ADDR_W,
  parameter logic [EW-1:0] EV_VALID = EVT_VALID
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] evt_pulse,
  input  logic [LW-1:0] lvl_flags,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          irq_a,
  output logic          irq_b
);
  localparam int SW = EW + LW;
  localparam int NI = N_IRQ;

  logic [EW-1:0]         evt_q;
  logic [SW-1:0]         stat_word;
  logic                  clr_en;
  logic [RW-1:0]         clr_val;
  logic [NI-1:0][RW-1:0] mask_w;
  logic [NI-1:0]         irq_w;

  sirq_evt_latch #(.W(EW), .VALID(EV_VALID)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_pulse),
    .clr_en_i(clr_en), .clr_val_i(clr_val[EW-1:0]), .q_o(evt_q)
  );

  assign stat_word = {lvl_flags, evt_q};

  sirq_regbank #(
    .REG_W(RW), .ADDR_W(AW), .STAT_W(SW), .N_MASK(NI),
    .CLR_ADDR(int'(A_CLR)), .STAT_ADDR(int'(A_STAT)), .MASK_BASE(int'(A_MASK0))
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .stat_i(stat_word), .rdata_o(reg_rdata),
    .clr_en_o(clr_en), .clr_val_o(clr_val), .mask_o(mask_w)
  );

  sirq_irq_gen #(.N(NI), .STAT_W(SW), .REG_W(RW)) u_irq (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_word), .mask_i(mask_w), .irq_o(irq_w)
  );

  assign irq_a = irq_w[0];
  assign irq_b = irq_w[1];
endmodule

// File: rtl/sirq_status_chk.sv
module sirq_status_chk (
  input logic              clk,
  input logic              rst_n,
  input logic [10:0]       evt_pulse,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              irq_a,
  input logic              irq_b,
  input logic [21:0]       stat_word,
  input logic [1:0][31:0]  mask_w
);
  localparam logic [10:0] VALIDM = 11'b101_1111_1111;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_a && !irq_b && stat_word[10:0] == '0 && mask_w == '0));

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_pulse & VALIDM) != '0) |=>
      ((stat_word[10:0] & $past(evt_pulse & VALIDM)) == $past(evt_pulse & VALIDM)));

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[9] == 1'b0);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1) |=>
      ((stat_word[10:0] & $past(reg_wdata[10:0] & ~evt_pulse)) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && ((reg_wdata[10:0] & evt_pulse & VALIDM) != '0)) |=>
      ((stat_word[10:0] & $past(reg_wdata[10:0] & evt_pulse & VALIDM)) != '0));

  p_irq_a_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a == $past(|(stat_word & mask_w[0][21:0])));

  p_irq_b_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b == $past(|(stat_word & mask_w[1][21:0])));

  p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd1 || reg_addr[2]) |-> (reg_rdata == '0));
endmodule

bind sirq_status_top sirq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_a(irq_a), .irq_b(irq_b), .stat_word(stat_word), .mask_w(mask_w)
);

// File: tb/tb_sirq_status_top.sv
`timescale 1ns/100ps
module tb_sirq_status_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] evt_pulse = '0;
  logic [10:0] lvl_flags = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [10:0] m_evt = '0;
  logic [31:0] m_mask [2];
  logic        exp_a = 0, exp_b = 0;

  always #2.5 clk = ~clk;

  sirq_status_top dut (.*);

  function automatic logic [21:0] f_stat(logic [10:0] ev, logic [10:0] lv);
    return {lv, ev};
  endfunction

  function automatic logic [31:0] f_read(logic [2:0] a, logic [10:0] ev, logic [10:0] lv,
                                         logic [31:0] ma, logic [31:0] mb);
    case (a)
      3'd0: return {10'b0, f_stat(ev, lv)};
      3'd2: return ma;
      3'd3: return mb;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle from a negedge; model updates at posedge; check irqs at next negedge
  task automatic cyc(logic [10:0] ev, logic [10:0] lv, logic wr, logic [2:0] a,
                     logic [31:0] wd, string tag);
    logic [10:0] clr;
    evt_pulse = ev; lvl_flags = lv; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    if (!wr) chk({tag, " read (R6/R7/R9)"}, reg_rdata, f_read(a, m_evt, lv, m_mask[0], m_mask[1]));
    @(posedge clk);
    exp_a = |(f_stat(m_evt, lv) & m_mask[0][21:0]);
    exp_b = |(f_stat(m_evt, lv) & m_mask[1][21:0]);
    clr = (wr && a == 3'd1) ? wd[10:0] : '0;
    m_evt = ((m_evt & ~clr) | ev) & 11'b101_1111_1111;
    if (wr && a == 3'd2) m_mask[0] = wd;
    if (wr && a == 3'd3) m_mask[1] = wd;
    @(negedge clk);
    chk({tag, " irq_a R8"}, {31'b0, irq_a}, {31'b0, exp_a});
    chk({tag, " irq_b R8"}, {31'b0, irq_b}, {31'b0, exp_b});
  endtask

  task automatic rd_stat(logic [10:0] lv, logic [31:0] exp, string tag);
    lvl_flags = lv; reg_wr = 0; reg_addr = 3'd0; evt_pulse = '0;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_mask[0] = '0; m_mask[1] = '0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 irq_a in reset", {31'b0, irq_a}, 32'b0);
    chk("R1 irq_b in reset", {31'b0, irq_b}, 32'b0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_stat('0, 32'h0, "R1 status after reset");
    reg_addr = 3'd2; #1 chk("R1 mask A after reset", reg_rdata, 32'h0);
    reg_addr = 3'd3; #1 chk("R1 mask B after reset", reg_rdata, 32'h0);
    @(negedge clk);

    // R2 sticky set
    cyc(11'h001, '0, 0, 3'd0, 0, "R2 set b0");
    cyc(11'h000, '0, 0, 3'd0, 0, "R2 hold");
    rd_stat('0, 32'h1, "R2 bit0 sticky");
    cyc(11'h400, '0, 0, 3'd0, 0, "R2 set b10");
    rd_stat('0, 32'h401, "R2 bit10 plus bit0");
    // R3 reserved bit
    cyc(11'h200, '0, 0, 3'd0, 0, "R3 pulse b9");
    rd_stat('0, 32'h401, "R3 bit9 stays zero");
    // R4 clear with upper data bits set
    cyc(11'h000, '0, 1, 3'd1, 32'hFFFF_F801, "R4 clear b0");
    rd_stat('0, 32'h400, "R4 only bit0 cleared");
    // R5 set and clear same cycle on several bits
    cyc(11'h0F0, '0, 1, 3'd1, 32'h0000_04F0, "R5 overlap");
    rd_stat('0, 32'h0F0, "R5 set wins, bit10 cleared");
    // R6 live levels, clear cannot touch them
    cyc(11'h000, 11'h7FF, 1, 3'd1, 32'hFFFF_FFFF, "R6 clear all");
    rd_stat(11'h7FF, {10'b0, 11'h7FF, 11'h000}, "R6 levels survive clear");
    rd_stat(11'h055, {10'b0, 11'h055, 11'h000}, "R6 level follows input");
    // R7 masks read back
    cyc('0, '0, 1, 3'd2, 32'hA5C3_0000, "R7 write mask A");
    cyc('0, '0, 1, 3'd3, 32'h0000_0040, "R7 write mask B");
    cyc('0, '0, 0, 3'd2, 0, "R7 read mask A");
    cyc('0, '0, 0, 3'd3, 0, "R7 read mask B");
    // R8 mask bits above status width ignored
    cyc('0, '0, 1, 3'd2, 32'hFFC0_0000, "R8 high mask");
    cyc(11'h0FF, 11'h7FF, 0, 3'd0, 0, "R8 high mask no irq");
    cyc('0, '0, 0, 3'd0, 0, "R8 settle");
    chk("R8 irq_a stays low with high-only mask", {31'b0, irq_a}, 32'b0);
    // R9 writes to read-only / unmapped addresses
    cyc('0, '0, 1, 3'd0, 32'hFFFF_FFFF, "R9 write status");
    cyc('0, '0, 1, 3'd5, 32'hFFFF_FFFF, "R9 write unmapped");
    rd_stat('0, {21'b0, m_evt}, "R9 status unchanged");
    cyc('0, '0, 0, 3'd1, 0, "R9 read clear reg");
    cyc('0, '0, 0, 3'd6, 0, "R9 read unmapped");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [10:0] ev, lv;
      logic wr;
      logic [2:0] a;
      logic [31:0] wd;
      ev = (($urandom % 4) == 0) ? 11'(1 << ($urandom % 11)) : '0;
      if (($urandom % 16) == 0) ev = ev | 11'($urandom);
      lv = (($urandom % 3) == 0) ? 11'(1 << ($urandom % 11)) : '0;
      wr = ($urandom % 3) == 0;
      case ($urandom % 6)
        0, 1, 2: a = 3'd1;
        3: a = 3'd2;
        4: a = 3'd3;
        default: a = 3'($urandom);
      endcase
      wd = $urandom;
      if (a == 3'd1 && ($urandom % 2)) wd = {21'b0, ev | 11'(1 << ($urandom % 11))};
      if (a == 3'd2 || a == 3'd3) wd = 32'(1 << ($urandom % 32)) | 32'(1 << ($urandom % 32));
      cyc(ev, lv, wr, a, wd, "RND R2/R4/R5");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule